// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Flags

This block performs the integer divides of a processor's execution stage: a 32-bit dividend by a 16-bit divisor (word form), 32 by 32 bits (long form), and a 64-bit dividend by a 32-bit divisor (wide form). Each form can be signed or unsigned. A one-cycle start pulse supplies the operand values read from the register file, the operation size, signedness, the current N flag and two register indices. The block then runs a restoring shift-subtract loop that produces one quotient bit per cycle, corrects the signs, and in one cycle presents the register write-backs, the N/Z/V/C flags and a done pulse. A zero divisor does not start the loop. Instead, the block raises a one-cycle exception pulse and writes nothing.

Overflow is detected exactly. When it occurs, no register is written, V is set, Z is cleared, C is cleared and N keeps its previous value. Two write ports carry results. Port 0 carries the remainder to the remainder index and port 1 carries the quotient to the quotient index. When both indices name the same register, the quotient wins. A compact-ISA mode changes which single value a 32 by 32 divide writes back.

Top module: `div_flag_unit`

## Requirements
- R1: A start is accepted only while idle. busy_o is high from the cycle after acceptance until done_o. done_o is a single-cycle pulse that appears 2*XLEN+1 clock edges after the edge that sampled start, which is 65 at the default width. A start given while busy has no effect on the result and produces no extra completion.
- R2: A zero effective divisor gives a dz_o pulse one edge after start, with no done_o, no write enable and no flag update. The effective divisor is the low 16 bits of dvs_i for the word form and all 32 bits otherwise.
- R3: flag_c_o is 0 on every completion, overflow included.
- R4: The word form overflows when the quotient exceeds 0xFFFF (unsigned) or lies outside -32768..32767 (signed). The 64/32 form overflows when the quotient does not fit in 32 unsigned or 32 signed bits. flag_v_o reports overflow.
- R5: On overflow, both write enables stay low, V=1 and Z=0, and N equals the n_i value that was sampled with start.
- R6: A word divide without overflow (size_i=0) writes only port 1. It writes {remainder[15:0], quotient[15:0]} to qidx_i, with N = quotient bit 15, Z = (quotient[15:0]==0) and V=0.
- R7: Signed quotients truncate toward zero. A signed remainder is zero or has the sign of the dividend.
- R8: The long form (size_i=1) divides lo_i by dvs_i. Unsigned long divides never overflow. A signed long divide overflows only for 0x80000000 divided by -1. On success N = quotient bit 31, Z = (quotient==0) and V=0.
- R9: The wide form (size_i=2 or 3) uses the dividend {hi_i, lo_i}, with hi_i read from the remainder register and lo_i from the quotient register. Its flags follow R8.
- R10: In standard mode a successful long or wide divide writes the remainder on port 0 to ridx_i and the quotient on port 1 to qidx_i. When ridx_i equals qidx_i, port 0 is suppressed, so that register ends up holding the quotient.
- R11: With compact_i=1, a long divide writes only the quotient on port 1 when the indices are equal, and only the remainder on port 0 when they differ. compact_i has no effect on the word or wide forms.
- R12: After reset, busy_o, done_o, dz_o, both write enables and flag_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| size_i | input | 2 | 0 word, 1 long, 2 or 3 wide |
| signed_i | input | 1 | Signed divide when 1 |
| compact_i | input | 1 | Compact-ISA write-back selection |
| lo_i | input | XLEN | Quotient register value (low dividend) |
| hi_i | input | XLEN | Remainder register value (high dividend, wide form) |
| dvs_i | input | XLEN | Divisor |
| qidx_i | input | IW | Quotient register index |
| ridx_i | input | IW | Remainder register index |
| n_i | input | 1 | Current N flag, kept on overflow |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | Completion pulse |
| dz_o | output | 1 | Divide-by-zero exception pulse |
| wr0_en_o | output | 1 | Remainder write enable |
| wr0_idx_o | output | IW | Remainder write index |
| wr0_data_o | output | XLEN | Remainder write value |
| wr1_en_o | output | 1 | Quotient write enable (applies last) |
| wr1_idx_o | output | IW | Quotient write index |
| wr1_data_o | output | XLEN | Quotient write value |
| flag_we_o | output | 1 | Flag update strobe |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Both write ports can be enabled in the same completion cycle. When the remainder and quotient indices coincide, only the quotient may reach the register. The bench provokes this with long and wide vectors whose two indices are equal, in standard and in compact mode, as well as with vectors whose indices differ. At the done pulse it compares both enables, both indices and both data values with a reference model built on native 64-bit arithmetic. Overflow is the second function that can meet the write-back in that cycle, and the bench judges it the same way: it expects both enables low while the flags show V set and N kept.

// File: rtl/divq_pkg.sv
package divq_pkg;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_LONG = 2'd1,
        SZ_WIDE = 2'd2,
        SZ_WIDX = 2'd3
    } div_size_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import divq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  div_size_e             size,
    input  logic                  sgn,
    input  logic [XLEN-1:0]       hi,
    input  logic [XLEN-1:0]       lo,
    input  logic [XLEN-1:0]       dvs,
    output logic [2*XLEN-1:0]     dvd_mag,
    output logic [XLEN-1:0]       dvs_mag,
    output logic                  neg_quo,
    output logic                  neg_rem,
    output logic                  dvs_zero
);
    localparam int HW = XLEN / 2;
    localparam int DW = 2 * XLEN;

    logic [DW-1:0]   dvd_ext;
    logic [XLEN-1:0] dvs_ext;
    logic            dvd_neg;
    logic            dvs_neg;

    always_comb begin
        unique case (size)
            SZ_WORD: begin
                dvd_ext = {{XLEN{sgn & lo[XLEN-1]}}, lo};
                dvs_ext = {{(XLEN-HW){sgn & dvs[HW-1]}}, dvs[HW-1:0]};
            end
            SZ_LONG: begin
                dvd_ext = {{XLEN{sgn & lo[XLEN-1]}}, lo};
                dvs_ext = dvs;
            end
            default: begin
                dvd_ext = {hi, lo};
                dvs_ext = dvs;
            end
        endcase
        dvd_neg  = sgn & dvd_ext[DW-1];
        dvs_neg  = sgn & dvs_ext[XLEN-1];
        dvd_mag  = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
        dvs_mag  = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
        neg_quo  = dvd_neg ^ dvs_neg;
        neg_rem  = dvd_neg;
        dvs_zero = (dvs_ext == '0);
    end

endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [2*XLEN-1:0]     dvd_mag,
    input  logic [XLEN-1:0]       dvs_mag,
    output logic [2*XLEN-1:0]     quo_mag,
    output logic [XLEN-1:0]       rem_mag,
    output logic                  fin
);
    localparam int DW = 2 * XLEN;
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic            active;
        logic            fin;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] rem;
        logic [DW-1:0]   quo;
        logic [XLEN-1:0] dvs;
    } core_t;

    core_t core_d, core_q;

    logic [XLEN:0]   shifted;
    logic [XLEN+1:0] trial;

    always_comb begin
        core_d     = core_q;
        core_d.fin = 1'b0;
        shifted    = {core_q.rem, core_q.quo[DW-1]};
        trial      = {1'b0, shifted} - {2'b00, core_q.dvs};
        if (load) begin
            core_d.active = 1'b1;
            core_d.cnt    = '0;
            core_d.rem    = '0;
            core_d.quo    = dvd_mag;
            core_d.dvs    = dvs_mag;
        end else if (core_q.active) begin
            if (!trial[XLEN+1]) begin
                core_d.rem = trial[XLEN-1:0];
                core_d.quo = {core_q.quo[DW-2:0], 1'b1};
            end else begin
                core_d.rem = shifted[XLEN-1:0];
                core_d.quo = {core_q.quo[DW-2:0], 1'b0};
            end
            core_d.cnt = core_q.cnt + 1'b1;
            if (core_q.cnt == LAST) begin
                core_d.active = 1'b0;
                core_d.fin    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign quo_mag = core_q.quo;
    assign rem_mag = core_q.rem;
    assign fin     = core_q.fin;

    // R7
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.active |-> (core_q.rem < core_q.dvs));

endmodule

// File: rtl/div_result_pack.sv
module div_result_pack
    import divq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IW   = 3
) (
    input  div_size_e             size,
    input  logic                  sgn,
    input  logic                  compact,
    input  logic [IW-1:0]         qidx,
    input  logic [IW-1:0]         ridx,
    input  logic                  n_keep,
    input  logic                  neg_quo,
    input  logic                  neg_rem,
    input  logic [2*XLEN-1:0]     quo_mag,
    input  logic [XLEN-1:0]       rem_mag,
    output logic                  ovf,
    output logic                  wr0_en,
    output logic [IW-1:0]         wr0_idx,
    output logic [XLEN-1:0]       wr0_data,
    output logic                  wr1_en,
    output logic [IW-1:0]         wr1_idx,
    output logic [XLEN-1:0]       wr1_data,
    output logic                  fn,
    output logic                  fz,
    output logic                  fv,
    output logic                  fc
);
    localparam int HW = XLEN / 2;
    localparam int DW = 2 * XLEN;

    logic [DW-1:0]   quo_s;
    logic [XLEN-1:0] rem_s;
    logic [DW-HW:0]  w_top;
    logic [XLEN:0]   l_top;
    logic            same_idx;

    always_comb begin
        quo_s    = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
        rem_s    = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
        w_top    = quo_s[DW-1:HW-1];
        l_top    = quo_s[DW-1:XLEN-1];
        same_idx = (qidx == ridx);

        if (size == SZ_WORD) begin
            ovf = sgn ? !((&w_top) | ~(|w_top)) : (|quo_s[DW-1:HW]);
        end else begin
            ovf = sgn ? !((&l_top) | ~(|l_top)) : (|quo_s[DW-1:XLEN]);
        end

        wr0_en   = 1'b0;
        wr1_en   = 1'b0;
        wr0_idx  = ridx;
        wr1_idx  = qidx;
        wr0_data = rem_s;
        wr1_data = quo_s[XLEN-1:0];
        fc       = 1'b0;

        if (size == SZ_WORD) begin
            wr1_data = {rem_s[HW-1:0], quo_s[HW-1:0]};
            fn       = quo_s[HW-1];
            fz       = (quo_s[HW-1:0] == '0);
        end else begin
            fn       = quo_s[XLEN-1];
            fz       = (quo_s[XLEN-1:0] == '0);
        end
        fv = 1'b0;

        if (ovf) begin
            fv = 1'b1;
            fz = 1'b0;
            fn = n_keep;
        end else begin
            unique case (size)
                SZ_WORD: wr1_en = 1'b1;
                SZ_LONG: begin
                    if (compact) begin
                        wr1_en = same_idx;
                        wr0_en = !same_idx;
                    end else begin
                        wr1_en = 1'b1;
                        wr0_en = !same_idx;
                    end
                end
                default: begin
                    wr1_en = 1'b1;
                    wr0_en = !same_idx;
                end
            endcase
        end
    end

endmodule

// File: rtl/div_flag_unit.sv
module div_flag_unit
    import divq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    input  logic              compact_i,
    input  logic [XLEN-1:0]   lo_i,
    input  logic [XLEN-1:0]   hi_i,
    input  logic [XLEN-1:0]   dvs_i,
    input  logic [IW-1:0]     qidx_i,
    input  logic [IW-1:0]     ridx_i,
    input  logic              n_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              dz_o,
    output logic              wr0_en_o,
    output logic [IW-1:0]     wr0_idx_o,
    output logic [XLEN-1:0]   wr0_data_o,
    output logic              wr1_en_o,
    output logic [IW-1:0]     wr1_idx_o,
    output logic [XLEN-1:0]   wr1_data_o,
    output logic              flag_we_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o,
    output logic              flag_c_o
);
    localparam int DW = 2 * XLEN;

    typedef struct packed {
        ctl_state_e      st;
        div_size_e       sz;
        logic            sg;
        logic            cp;
        logic [IW-1:0]   qi;
        logic [IW-1:0]   ri;
        logic            nk;
        logic            nq;
        logic            nr;
        logic            done;
        logic            dz;
        logic            wr0_en;
        logic [IW-1:0]   wr0_idx;
        logic [XLEN-1:0] wr0_data;
        logic            wr1_en;
        logic [IW-1:0]   wr1_idx;
        logic [XLEN-1:0] wr1_data;
        logic            fwe;
        logic            fn;
        logic            fz;
        logic            fv;
        logic            fc;
    } top_t;

    top_t top_d, top_q;

    div_size_e       size_in;
    logic [DW-1:0]   dvd_mag;
    logic [XLEN-1:0] dvs_mag;
    logic            neg_quo;
    logic            neg_rem;
    logic            dvs_zero;
    logic            core_load;
    logic [DW-1:0]   quo_mag;
    logic [XLEN-1:0] rem_mag;
    logic            core_fin;

    logic            pk_ovf;
    logic            pk_wr0_en;
    logic [IW-1:0]   pk_wr0_idx;
    logic [XLEN-1:0] pk_wr0_data;
    logic            pk_wr1_en;
    logic [IW-1:0]   pk_wr1_idx;
    logic [XLEN-1:0] pk_wr1_data;
    logic            pk_fn;
    logic            pk_fz;
    logic            pk_fv;
    logic            pk_fc;

    assign size_in = div_size_e'(size_i);

    div_operand_prep #(.XLEN(XLEN)) u_prep (
        .size     (size_in),
        .sgn      (signed_i),
        .hi       (hi_i),
        .lo       (lo_i),
        .dvs      (dvs_i),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .neg_quo  (neg_quo),
        .neg_rem  (neg_rem),
        .dvs_zero (dvs_zero)
    );

    div_shift_core #(.XLEN(XLEN)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (core_load),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .fin     (core_fin)
    );

    div_result_pack #(.XLEN(XLEN), .IW(IW)) u_pack (
        .size     (top_q.sz),
        .sgn      (top_q.sg),
        .compact  (top_q.cp),
        .qidx     (top_q.qi),
        .ridx     (top_q.ri),
        .n_keep   (top_q.nk),
        .neg_quo  (top_q.nq),
        .neg_rem  (top_q.nr),
        .quo_mag  (quo_mag),
        .rem_mag  (rem_mag),
        .ovf      (pk_ovf),
        .wr0_en   (pk_wr0_en),
        .wr0_idx  (pk_wr0_idx),
        .wr0_data (pk_wr0_data),
        .wr1_en   (pk_wr1_en),
        .wr1_idx  (pk_wr1_idx),
        .wr1_data (pk_wr1_data),
        .fn       (pk_fn),
        .fz       (pk_fz),
        .fv       (pk_fv),
        .fc       (pk_fc)
    );

    always_comb begin
        top_d        = top_q;
        top_d.done   = 1'b0;
        top_d.dz     = 1'b0;
        top_d.wr0_en = 1'b0;
        top_d.wr1_en = 1'b0;
        top_d.fwe    = 1'b0;
        core_load    = 1'b0;
        unique case (top_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (dvs_zero) begin
                        top_d.dz = 1'b1;
                    end else begin
                        core_load = 1'b1;
                        top_d.st  = ST_BUSY;
                        top_d.sz  = size_in;
                        top_d.sg  = signed_i;
                        top_d.cp  = compact_i;
                        top_d.qi  = qidx_i;
                        top_d.ri  = ridx_i;
                        top_d.nk  = n_i;
                        top_d.nq  = neg_quo;
                        top_d.nr  = neg_rem;
                    end
                end
            end
            default: begin
                if (core_fin) begin
                    top_d.st       = ST_IDLE;
                    top_d.done     = 1'b1;
                    top_d.fwe      = 1'b1;
                    top_d.wr0_en   = pk_wr0_en;
                    top_d.wr0_idx  = pk_wr0_idx;
                    top_d.wr0_data = pk_wr0_data;
                    top_d.wr1_en   = pk_wr1_en;
                    top_d.wr1_idx  = pk_wr1_idx;
                    top_d.wr1_data = pk_wr1_data;
                    top_d.fn       = pk_fn;
                    top_d.fz       = pk_fz;
                    top_d.fv       = pk_fv;
                    top_d.fc       = pk_fc;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign busy_o     = (top_q.st == ST_BUSY);
    assign done_o     = top_q.done;
    assign dz_o       = top_q.dz;
    assign wr0_en_o   = top_q.wr0_en;
    assign wr0_idx_o  = top_q.wr0_idx;
    assign wr0_data_o = top_q.wr0_data;
    assign wr1_en_o   = top_q.wr1_en;
    assign wr1_idx_o  = top_q.wr1_idx;
    assign wr1_data_o = top_q.wr1_data;
    assign flag_we_o  = top_q.fwe;
    assign flag_n_o   = top_q.fn;
    assign flag_z_o   = top_q.fz;
    assign flag_v_o   = top_q.fv;
    assign flag_c_o   = top_q.fc;

    // R2
    dz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dz_o |-> (!done_o && !flag_we_o && !wr0_en_o && !wr1_en_o));

    // R5
    ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_o && flag_v_o) |-> (!wr0_en_o && !wr1_en_o && !flag_z_o));

    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> !flag_c_o);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en_o && wr1_en_o) |-> (wr0_idx_o != wr1_idx_o));

endmodule

// File: tb/sim_div_flag_unit.sv
`timescale 1ns/1ps
module sim_div_flag_unit;

    localparam int LAT = 65;
    localparam int NV  = 22;

    typedef struct packed {
        logic [1:0]  sz;
        logic        sg;
        logic        cp;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] dv;
        logic [2:0]  qi;
        logic [2:0]  ri;
        logic        nk;
        logic        xo;
    } vec_t;

    // size, signed, compact, hi, lo, divisor, qidx, ridx, n_in, expected overflow
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 1'b0, 32'h0, 32'd100,        32'd7,          3'd1, 3'd2, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 32'h0, 32'h0010_0000,  32'd16,         3'd1, 3'd2, 1'b1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 32'h0, 32'h000F_FFFF,  32'd16,         3'd3, 3'd3, 1'b0, 1'b0},
        '{2'd0, 1'b1, 1'b0, 32'h0, 32'hFFFF_FF9C,  32'd7,          3'd1, 3'd1, 1'b0, 1'b0},
        '{2'd0, 1'b1, 1'b0, 32'h0, 32'd100,        32'h1234_FFF9,  3'd2, 3'd3, 1'b0, 1'b0},
        '{2'd0, 1'b1, 1'b0, 32'h0, 32'h0000_8000,  32'd1,          3'd4, 3'd4, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b0, 32'h0, 32'hFFFF_8000,  32'd1,          3'd4, 3'd5, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b0, 32'h0, 32'h8000_0000,  32'h0000_FFFF,  3'd5, 3'd5, 1'b1, 1'b1},
        '{2'd0, 1'b0, 1'b0, 32'h0, 32'd5,          32'd9,          3'd6, 3'd7, 1'b1, 1'b0},
        '{2'd1, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF,  32'd3,          3'd3, 3'd4, 1'b0, 1'b0},
        '{2'd1, 1'b1, 1'b0, 32'h0, 32'h8000_0000,  32'hFFFF_FFFF,  3'd1, 3'd2, 1'b1, 1'b1},
        '{2'd1, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFF9,  32'd2,          3'd6, 3'd5, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 32'h0, 32'd1000,       32'd7,          3'd2, 3'd2, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b1, 32'h0, 32'd50,         32'd8,          3'd1, 3'd1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b1, 32'h0, 32'd50,         32'd8,          3'd1, 3'd2, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 32'd1, 32'h0,          32'd2,          3'd0, 3'd1, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 32'd2, 32'h0,          32'd2,          3'd0, 3'd1, 1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0,  32'd2,          3'd2, 3'd3, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b0, 32'h0, 32'h8000_0000,  32'd1,          3'd2, 3'd3, 1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 32'h0, 32'd123456,     32'd1000,       3'd0, 3'd7, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b1, 32'h0, 32'd100,        32'd7,          3'd1, 3'd2, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 3'd4, 3'd4, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        signed_i = 1'b0;
    logic        compact_i = 1'b0;
    logic [31:0] lo_i = '0;
    logic [31:0] hi_i = '0;
    logic [31:0] dvs_i = '0;
    logic [2:0]  qidx_i = '0;
    logic [2:0]  ridx_i = '0;
    logic        n_i = 1'b0;
    logic        busy_o, done_o, dz_o;
    logic        wr0_en_o, wr1_en_o;
    logic [2:0]  wr0_idx_o, wr1_idx_o;
    logic [31:0] wr0_data_o, wr1_data_o;
    logic        flag_we_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    div_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .signed_i(signed_i), .compact_i(compact_i), .lo_i(lo_i), .hi_i(hi_i),
        .dvs_i(dvs_i), .qidx_i(qidx_i), .ridx_i(ridx_i), .n_i(n_i),
        .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
        .wr0_en_o(wr0_en_o), .wr0_idx_o(wr0_idx_o), .wr0_data_o(wr0_data_o),
        .wr1_en_o(wr1_en_o), .wr1_idx_o(wr1_idx_o), .wr1_data_o(wr1_data_o),
        .flag_we_o(flag_we_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference from the requirements using native 64-bit arithmetic.
    task automatic model(input vec_t v, output logic ovf, output logic w0e,
                         output logic w1e, output logic [31:0] w0d,
                         output logic [31:0] w1d, output logic n, output logic z);
        logic [63:0] a, b, q, r;
        longint sa, sb, sq, sr;
        case (v.sz)
            2'd0: begin
                a = v.sg ? {{32{v.lo[31]}}, v.lo} : {32'h0, v.lo};
                b = v.sg ? {{48{v.dv[15]}}, v.dv[15:0]} : {48'h0, v.dv[15:0]};
            end
            2'd1: begin
                a = v.sg ? {{32{v.lo[31]}}, v.lo} : {32'h0, v.lo};
                b = v.sg ? {{32{v.dv[31]}}, v.dv} : {32'h0, v.dv};
            end
            default: begin
                a = {v.hi, v.lo};
                b = v.sg ? {{32{v.dv[31]}}, v.dv} : {32'h0, v.dv};
            end
        endcase
        if (v.sg) begin
            sa = a; sb = b; sq = sa / sb; sr = sa % sb;
            q = sq; r = sr;
            if (v.sz == 2'd0) ovf = (sq > 64'sd32767) || (sq < -64'sd32768);
            else              ovf = (sq > 64'sd2147483647) || (sq < -64'sd2147483648);
        end else begin
            q = a / b; r = a % b;
            if (v.sz == 2'd0) ovf = (q > 64'hFFFF);
            else              ovf = (q > 64'hFFFF_FFFF);
        end
        w0e = 1'b0; w1e = 1'b0; w0d = r[31:0]; w1d = q[31:0];
        if (ovf) begin
            n = v.nk; z = 1'b0;
        end else if (v.sz == 2'd0) begin
            w1e = 1'b1; w1d = {r[15:0], q[15:0]};
            n = q[15]; z = (q[15:0] == 16'h0);
        end else begin
            n = q[31]; z = (q[31:0] == 32'h0);
            if (v.sz == 2'd1 && v.cp) begin
                w1e = (v.qi == v.ri); w0e = (v.qi != v.ri);
            end else begin
                w1e = 1'b1; w0e = (v.qi != v.ri);
            end
        end
    endtask

    task automatic drive(input vec_t v);
        size_i = v.sz; signed_i = v.sg; compact_i = v.cp;
        hi_i = v.hi; lo_i = v.lo; dvs_i = v.dv;
        qidx_i = v.qi; ridx_i = v.ri; n_i = v.nk;
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        drive(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_end(output int e);
        e = 0;
        while (!done_o && !dz_o && e < 300) begin
            @(negedge clk);
            e++;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t v;
        logic eo, e0, e1, en, ez;
        logic [31:0] d0, d1;
        int e;
        string ft, wt;
        logic [3:0] held;
        bit seen;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy_o && !done_o && !dz_o, "R12", "ctl after reset",
            {busy_o, done_o, dz_o}, 0);
        chk(!wr0_en_o && !wr1_en_o && !flag_we_o, "R12", "enables after reset",
            {wr0_en_o, wr1_en_o, flag_we_o}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VT[i];
            model(v, eo, e0, e1, d0, d1, en, ez);
            launch(v);
            chk(busy_o === 1'b1, "R1", "busy after start", busy_o, 1);
            wait_end(e);
            chk(done_o && e == LAT, "R1", "done latency", e, LAT);
            ft = v.xo ? "R5" : (v.sz == 2'd0) ? "R6" : (v.sz == 2'd1) ? "R8" : "R9";
            wt = (v.cp && v.sz == 2'd1) ? "R11" :
                 (v.sz != 2'd0 && v.qi == v.ri) ? "R10" :
                 v.sg ? "R7" : ft;
            chk(flag_v_o == v.xo && eo == v.xo, "R4", "overflow flag", flag_v_o, v.xo);
            chk(flag_c_o == 1'b0 && flag_we_o, "R3", "carry clear", {flag_we_o, flag_c_o}, 2);
            chk(flag_n_o == en && flag_z_o == ez, ft, "N,Z",
                {flag_n_o, flag_z_o}, {en, ez});
            chk(wr0_en_o == e0 && wr1_en_o == e1, wt, "write enables",
                {wr0_en_o, wr1_en_o}, {e0, e1});
            if (e0)
                chk(wr0_data_o == d0 && wr0_idx_o == v.ri, wt, "port0 remainder",
                    {wr0_idx_o, wr0_data_o}, {v.ri, d0});
            if (e1)
                chk(wr1_data_o == d1 && wr1_idx_o == v.qi, wt, "port1 quotient",
                    {wr1_idx_o, wr1_data_o}, {v.qi, d1});
        end

        // R1: second start while busy is ignored
        v = VT[9];
        launch(v);
        repeat (5) @(negedge clk);
        v = VT[0];
        drive(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end(e);
        chk(done_o && wr1_data_o == 32'h5555_5555, "R1", "start while busy",
            wr1_data_o, 32'h5555_5555);
        seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (done_o || dz_o) seen = 1'b1;
        end
        chk(!seen, "R1", "no extra completion", seen, 0);

        // R2: word divide with zero low half, nonzero upper half
        held = {flag_n_o, flag_z_o, flag_v_o, flag_c_o};
        v = '{2'd0, 1'b0, 1'b0, 32'h0, 32'd5, 32'hABCD_0000, 3'd1, 3'd2, 1'b1, 1'b0};
        launch(v);
        chk(dz_o && !done_o && !wr0_en_o && !wr1_en_o && !flag_we_o, "R2",
            "word zero divisor", {dz_o, done_o, wr0_en_o, wr1_en_o, flag_we_o}, 5'b10000);
        @(negedge clk);
        chk(!dz_o && !busy_o, "R2", "dz single pulse", {dz_o, busy_o}, 0);
        seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (done_o || flag_we_o) seen = 1'b1;
        end
        chk(!seen && {flag_n_o, flag_z_o, flag_v_o, flag_c_o} == held, "R2",
            "flags untouched", {flag_n_o, flag_z_o, flag_v_o, flag_c_o}, held);

        // R2: wide divide with zero divisor
        v = '{2'd2, 1'b1, 1'b0, 32'h7, 32'd5, 32'h0, 3'd1, 3'd2, 1'b0, 1'b0};
        launch(v);
        chk(dz_o && !done_o && !flag_we_o, "R2", "wide zero divisor",
            {dz_o, done_o, flag_we_o}, 3'b100);

        // R9, R5: wide overflow keeps N low when n_i is low
        v = '{2'd2, 1'b0, 1'b0, 32'h10, 32'h0, 32'h8, 3'd1, 3'd2, 1'b0, 1'b1};
        launch(v);
        wait_end(e);
        chk(done_o && flag_v_o && !flag_n_o && !flag_z_o && !wr0_en_o && !wr1_en_o,
            "R5", "wide overflow N kept", {flag_v_o, flag_n_o, flag_z_o}, 3'b100);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule